// File: doc/BRIEF.md
# Halt and Idle Power-State Controller

This block decides when a small processor core may stop its clocks and when it must start them again. Software asks for one of two low-power states. The deep state gates every clock, including the timer. The light state stops only the core clock and leaves the timer counting. A halt-enable bit guards entry into the deep state. That bit can be written once after reset and then stays locked until the next reset.

Three things end a low-power state. A reset ends either state and returns the controller to its power-up condition. A non-maskable interrupt pulse ends either state and raises a one-cycle vector request. A timer overflow ends the light state only. Leaving the deep state always passes through an oscillator-settling window of `STAB_CYCLES` cycles before the core clock returns. Leaving the light state skips that window.

An interrupt that arrives in the same cycle as the entry request does not stop the entry. It is held as pending and is serviced when the state is left. The controller holds no data and resets none: RAM, registers and I/O keep their values.

Top module: `lp_power_ctl`

## Requirements
- R1: Reset state: `core_clk_en`=1, `tmr_clk_en`=1, `stab_wait`=0, `nmi_pend`=0, `vec_req`=0, and the halt-enable bit is cleared and unlocked. An asynchronous reset also ends a low-power state.
- R2: The first `hen_wr` after reset loads `hen_wdata` into the halt-enable bit and locks it. Later writes have no effect until reset.
- R3: A `halt_req` while the halt-enable bit is 0 is ignored, and both clock enables stay at 1.
- R4: An accepted `halt_req` drives `core_clk_en`=0 and `tmr_clk_en`=0 from the next cycle on.
- R5: An `idle_req` drives `core_clk_en`=0 and keeps `tmr_clk_en`=1 from the next cycle on.
- R6: A `t0_ovf` pulse in the light state restores `core_clk_en` on the next cycle, with no settling window. In the deep state, `t0_ovf` has no effect.
- R7: An `nmi` pulse in the light state restores `core_clk_en` on the next cycle and pulses `vec_req` in that cycle, with no settling window.
- R8: An `nmi` pulse in the deep state holds `stab_wait`=1 with both clock enables at 0 for exactly `STAB_CYCLES` cycles. In the cycle after that, both enables return to 1 and `vec_req` pulses.
- R9: An `nmi` pulse in the same cycle as an accepted request still enters the state and sets `nmi_pend`=1 for the whole stay. If the light state is then left by `t0_ovf`, `vec_req` pulses in the first running cycle.
- R10: An `nmi` pulse while running and not entering a state produces `vec_req`=1 in the next cycle, with no change to the clock enables.
- R11: If `halt_req` and `idle_req` arrive together, the deep state wins when halt is enabled. Otherwise the light state is entered.
- R12: `nmi_pend` is 0 in every cycle where `vec_req`=1. Each vector request lasts one cycle per interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle software request for the deep state |
| idle_req | input | 1 | One-cycle software request for the light state |
| hen_wr | input | 1 | Write strobe for the halt-enable bit |
| hen_wdata | input | 1 | Value written to the halt-enable bit |
| nmi | input | 1 | One-cycle non-maskable interrupt pulse |
| t0_ovf | input | 1 | One-cycle timer overflow pulse |
| core_clk_en | output | 1 | Core clock gate enable |
| tmr_clk_en | output | 1 | Timer clock gate enable |
| stab_wait | output | 1 | Oscillator settling window in progress |
| nmi_pend | output | 1 | An interrupt is held and not yet vectored |
| vec_req | output | 1 | One-cycle request to vector the interrupt |

## Verification
The main function is exercised with several input patterns:
- A halt request with halt disabled separates "ignored" from "entered".
- A timer overflow in each state separates the wake rule of the light state from that of the deep state.
- An interrupt in each state shows whether the settling window appears or is skipped.
- An interrupt coinciding with an entry request checks that entry proceeds and that the pending flag carries the interrupt to the exit.

Writes before and after the lock, repeated across a mid-test reset, show that only the first write counts and that reset alone reopens the bit.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [1:0] {
    LP_RUN  = 2'd0,
    LP_HALT = 2'd1,
    LP_IDLE = 2'd2,
    LP_STAB = 2'd3
  } lp_state_e;

  // core clock runs only in the normal running state
  function automatic logic core_on(lp_state_e s);
    return s == LP_RUN;
  endfunction

  // timer clock runs while running and while idling
  function automatic logic tmr_on(lp_state_e s);
    return (s == LP_RUN) || (s == LP_IDLE);
  endfunction

  // value loaded into the settling counter for a window of n cycles
  function automatic int unsigned stab_load(int unsigned n);
    return (n > 0) ? n - 1 : 0;
  endfunction

endpackage

// File: rtl/lp_once_reg.sv
module lp_once_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  output logic val_q,
  output logic lock_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr && !lock_q) begin
      val_q  <= wdata;
      lock_q <= 1'b1;
    end
  end

endmodule

// File: rtl/lp_stab_timer.sv
module lp_stab_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(lp_pkg::stab_load(CYCLES));

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= LOAD;
      busy  <= 1'b1;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy && (cnt_q == '0);

endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt_req,
  input  logic      idle_req,
  input  logic      halt_en,
  input  logic      nmi,
  input  logic      t0_ovf,
  input  logic      stab_done,
  output lp_state_e state_q,
  output logic      pend_q,
  output logic      vec_q,
  output logic      ev_stab_start
);

  lp_state_e state_d;
  logic      pend_d;
  logic      vec_d;
  logic      go_halt, go_idle, run_nmi;
  logic      idle_wake_nmi, idle_wake_tmr, halt_wake, stab_end;

  always_comb begin
    go_halt       = (state_q == LP_RUN) && halt_req && halt_en;
    go_idle       = (state_q == LP_RUN) && idle_req && !go_halt;
    run_nmi       = (state_q == LP_RUN) && nmi && !go_halt && !go_idle;
    idle_wake_nmi = (state_q == LP_IDLE) && nmi;
    idle_wake_tmr = (state_q == LP_IDLE) && t0_ovf && !nmi;
    halt_wake     = (state_q == LP_HALT) && nmi;
    stab_end      = (state_q == LP_STAB) && stab_done;

    state_d = state_q;
    if (go_halt)                          state_d = LP_HALT;
    else if (go_idle)                     state_d = LP_IDLE;
    else if (idle_wake_nmi || idle_wake_tmr) state_d = LP_RUN;
    else if (halt_wake)                   state_d = LP_STAB;
    else if (stab_end)                    state_d = LP_RUN;

    vec_d = run_nmi || idle_wake_nmi || (idle_wake_tmr && pend_q) || stab_end;

    pend_d = pend_q;
    if (go_halt || go_idle) pend_d = nmi;
    else if (halt_wake)     pend_d = 1'b1;
    else if (vec_d)         pend_d = 1'b0;
  end

  assign ev_stab_start = halt_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LP_RUN;
      pend_q  <= 1'b0;
      vec_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      vec_q   <= vec_d;
    end
  end

endmodule

// File: rtl/lp_power_ctl.sv
module lp_power_ctl
  import lp_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic idle_req,
  input  logic hen_wr,
  input  logic hen_wdata,
  input  logic nmi,
  input  logic t0_ovf,
  output logic core_clk_en,
  output logic tmr_clk_en,
  output logic stab_wait,
  output logic nmi_pend,
  output logic vec_req
);

  logic      hen_q;
  logic      hen_lock_q;
  logic      ev_stab_start;
  logic      stab_busy;
  logic      stab_done;
  lp_state_e state_q;

  lp_once_reg u_hen (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (hen_wr),
    .wdata  (hen_wdata),
    .val_q  (hen_q),
    .lock_q (hen_lock_q)
  );

  lp_stab_timer #(.CYCLES(STAB_CYCLES)) u_stab (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_stab_start),
    .busy  (stab_busy),
    .done  (stab_done)
  );

  lp_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_req      (halt_req),
    .idle_req      (idle_req),
    .halt_en       (hen_q),
    .nmi           (nmi),
    .t0_ovf        (t0_ovf),
    .stab_done     (stab_done),
    .state_q       (state_q),
    .pend_q        (nmi_pend),
    .vec_q         (vec_req),
    .ev_stab_start (ev_stab_start)
  );

  assign core_clk_en = core_on(state_q);
  assign tmr_clk_en  = tmr_on(state_q);
  assign stab_wait   = (state_q == LP_STAB);

endmodule

// File: rtl/lp_power_ctl_chk.sv
module lp_power_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_req,
  input logic idle_req,
  input logic nmi,
  input logic t0_ovf,
  input logic core_clk_en,
  input logic tmr_clk_en,
  input logic stab_wait,
  input logic nmi_pend,
  input logic vec_req,
  input logic hen_q,
  input logic hen_lock_q,
  input logic stab_busy
);

  assert_locked_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hen_lock_q |=> ($stable(hen_q) && hen_lock_q));

  assert_halt_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !idle_req && !hen_q && core_clk_en) |=> core_clk_en);

  assert_ovf_no_halt_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && !tmr_clk_en && !stab_wait && t0_ovf && !nmi) |=> !core_clk_en);

  assert_idle_nmi_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clk_en && !core_clk_en && nmi) |=> (core_clk_en && vec_req));

  assert_settle_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stab_wait |-> (!core_clk_en && !tmr_clk_en && stab_busy));

  assert_vec_clears_pend_R12: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> !nmi_pend);

endmodule

bind lp_power_ctl lp_power_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .halt_req    (halt_req),
  .idle_req    (idle_req),
  .nmi         (nmi),
  .t0_ovf      (t0_ovf),
  .core_clk_en (core_clk_en),
  .tmr_clk_en  (tmr_clk_en),
  .stab_wait   (stab_wait),
  .nmi_pend    (nmi_pend),
  .vec_req     (vec_req),
  .hen_q       (hen_q),
  .hen_lock_q  (hen_lock_q),
  .stab_busy   (stab_busy)
);

// File: tb/sim_lp_power_ctl.sv
`timescale 1ns/1ps
module sim_lp_power_ctl;

  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, idle_req = 0, hen_wr = 0, hen_wdata = 0, nmi = 0, t0_ovf = 0;
  logic core_clk_en, tmr_clk_en, stab_wait, nmi_pend, vec_req;

  always #5 clk = ~clk;

  lp_power_ctl #(.STAB_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .idle_req(idle_req),
    .hen_wr(hen_wr), .hen_wdata(hen_wdata), .nmi(nmi), .t0_ovf(t0_ovf),
    .core_clk_en(core_clk_en), .tmr_clk_en(tmr_clk_en), .stab_wait(stab_wait),
    .nmi_pend(nmi_pend), .vec_req(vec_req)
  );

  typedef struct {
    int         cyc;
    logic [4:0] v;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // vector order: {core, tmr, stab, pend, vec}
  task automatic expect_at(int d, logic [4:0] v, string tag);
    exp_t e;
    e.cyc = cyc + d; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_in();
    halt_req = 0; idle_req = 0; hen_wr = 0; hen_wdata = 0; nmi = 0; t0_ovf = 0;
  endtask

  // monitor: compares scoreboard items against the ports away from the edge
  always @(negedge clk) begin
    logic [4:0] act;
    act = {core_clk_en, tmr_clk_en, stab_wait, nmi_pend, vec_req};
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (e.cyc < cyc) begin
        n_fail++;
        $display("FAIL %s: sample missed at cycle %0d, expected %b", e.tag, e.cyc, e.v);
      end else if (act !== e.v) begin
        n_fail++;
        $display("FAIL %s: cycle %0d actual %b expected %b", e.tag, cyc, act, e.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    ticks(3);
    rst_n = 1;
    // R1 reset state
    expect_at(1, 5'b11000, "R1"); tick();

    // R3 halt refused while disabled
    halt_req = 1;
    expect_at(1, 5'b11000, "R3"); expect_at(2, 5'b11000, "R3");
    tick(); clear_in(); ticks(2);

    // R5 idle, R6 timer wake without settling
    idle_req = 1; expect_at(1, 5'b01000, "R5"); tick(); clear_in();
    expect_at(1, 5'b01000, "R5"); tick();
    t0_ovf = 1; expect_at(1, 5'b11000, "R6"); tick(); clear_in(); tick();

    // R2 first write enables, second write ignored; R4 halt gating
    hen_wr = 1; hen_wdata = 1; tick(); clear_in();
    hen_wr = 1; hen_wdata = 0; tick(); clear_in();
    halt_req = 1; expect_at(1, 5'b00000, "R2"); tick(); clear_in();
    expect_at(1, 5'b00000, "R4");
    t0_ovf = 1; expect_at(1, 5'b00000, "R6"); tick(); clear_in();
    expect_at(1, 5'b00000, "R6"); tick();

    // R8 nmi leaves halt through settling window
    nmi = 1;
    for (int i = 1; i <= S; i++) expect_at(i, 5'b00110, "R8");
    expect_at(S + 1, 5'b11001, "R8");
    expect_at(S + 2, 5'b11000, "R12");
    tick(); clear_in(); ticks(S + 2);

    // R7 nmi leaves idle directly
    idle_req = 1; tick(); clear_in();
    nmi = 1; expect_at(1, 5'b11001, "R7"); expect_at(2, 5'b11000, "R7");
    tick(); clear_in(); ticks(2);

    // R9 nmi during idle entry, then timer wake services it
    idle_req = 1; nmi = 1; expect_at(1, 5'b01010, "R9"); tick(); clear_in();
    expect_at(2, 5'b01010, "R9"); ticks(2);
    t0_ovf = 1; expect_at(1, 5'b11001, "R9"); expect_at(2, 5'b11000, "R12");
    tick(); clear_in(); ticks(2);

    // R9 nmi during halt entry, fresh nmi wakes
    halt_req = 1; nmi = 1; expect_at(1, 5'b00010, "R9"); tick(); clear_in();
    nmi = 1;
    for (int i = 1; i <= S; i++) expect_at(i, 5'b00110, "R9");
    expect_at(S + 1, 5'b11001, "R9");
    tick(); clear_in(); ticks(S + 2);

    // R10 nmi while running
    nmi = 1; expect_at(1, 5'b11001, "R10"); expect_at(2, 5'b11000, "R10");
    tick(); clear_in(); ticks(2);

    // R11 both requests, halt enabled -> halt
    halt_req = 1; idle_req = 1; expect_at(1, 5'b00000, "R11"); tick(); clear_in();
    nmi = 1; tick(); clear_in(); ticks(S + 2);

    // R1 reset from idle
    idle_req = 1; tick(); clear_in();
    rst_n = 0; tick(); rst_n = 1;
    expect_at(1, 5'b11000, "R1"); tick();

    // R2 reset reopened lock: halt disabled again; R11 both -> idle
    halt_req = 1; expect_at(1, 5'b11000, "R2"); tick(); clear_in();
    halt_req = 1; idle_req = 1; expect_at(1, 5'b01000, "R11"); tick(); clear_in();
    t0_ovf = 1; tick(); clear_in(); tick();

    // R2 first write 0 locks, later write 1 ignored
    hen_wr = 1; hen_wdata = 0; tick(); clear_in();
    hen_wr = 1; hen_wdata = 1; tick(); clear_in();
    halt_req = 1; expect_at(1, 5'b11000, "R2"); expect_at(2, 5'b11000, "R3");
    tick(); clear_in(); ticks(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule